// File: doc/BRIEF.md
# Single-Channel Block Mover with Frame-Reloaded Table Walk

This block is one channel of a byte mover that masters a 16-bit, byte-wide bus. In block mode, started by a one-cycle `start` pulse, it reads bytes from a source address and writes each one to a fixed destination port. The port sits at the address formed by a page constant above an 8-bit port number. The source address and the byte count are working registers. They change in place as the block runs, and the CPU can read them at any time. Nothing restores them after a run, so a second start with nothing rewritten picks up where the first one stopped.

In table mode, started by `frame_start`, the channel walks a list of entries. The programmed start address is never touched. On every frame pulse it is copied into a separate working table pointer, and only that pointer advances, so each frame replays the same table. Entries either carry their data bytes inline, or they carry a 16-bit pointer through which the data is fetched. The pointer form has one end-of-table shortcut. When the channel is flagged as the last one active, it reads only one pointer byte, places that byte in the upper half of the pointer register, and finishes one bus slot earlier.

Each bus access occupies a slot of `SLOT_CYC` clocks, eight by default. The strobe is high in the first clock of the slot, and read data is sampled in that same clock.

Top module: `dmac_chan`

## Requirements
- R1: In block mode the source register moves by one after each byte read: up when ctrl bit 0 is 0, down when it is 1. At the end it holds the address just past the last byte read.
- R2: The count register (offsets 4/5) drops by one at the end of every read slot, and the block ends when the count reaches 0x0000. A count of 0x0000 at start therefore means 65536 bytes, and it reads 0xFFFF after the first byte.
- R3: The engine never clears or restores registers. A start with the source left unwritten continues from the updated source address.
- R4: Each block byte is one read at the source address, followed by one write of that byte to address {PORT_PAGE, port}.
- R5: A frame pulse copies the start address (offsets 2/3) into the working table pointer (offsets 8/9, read-only), and the table walk never changes the start address. A second frame repeats the same bus traffic.
- R6: A header byte with low 7 bits equal to zero ends the table. Otherwise, if bit 7 is 1, the low 7 bits give the number of data bytes that follow. If bit 7 is 0, exactly one data byte follows.
- R7: With ctrl bit 1 set, every non-final header is followed by a pointer, low byte first. Data bytes are read through the pointer register (offsets 6/7), which increments once per byte.
- R8: Pointer mode, final header, `last_chan` low: the next two bytes are read into the pointer register. With `last_chan` high, only one byte is read, the pointer register becomes {that byte, 0x00}, and `done` arrives `SLOT_CYC` clocks sooner.
- R9: Each bus access is a one-clock strobe per slot of `SLOT_CYC` clocks. `busy` is high while a run is active, and `done` is a single-cycle pulse at the end of a run, with `busy` low.
- R10: CPU writes while `busy` is high have no effect. CPU reads while busy return the current working values.
- R11: After reset all registers read zero, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 4 | Register offset: 0 ctrl, 1 port, 2/3 start, 4/5 count, 6/7 pointer, 8/9 table pointer |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| start | input | 1 | Starts a block run when idle |
| frame_start | input | 1 | Reloads the table pointer and starts a table walk when idle |
| last_chan | input | 1 | Marks this channel as the last active one at table end |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, sampled with the read strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is the shortened end of a pointer-mode table. It needs pointer mode, a final header, and `last_chan` high all at once. The bench runs the same pointer table twice, once with `last_chan` low and once with it high, and compares the bus traffic, the final pointer value and the cycle count between `frame_start` and `done`. The 65536-byte meaning of a zero count cannot be run to completion within budget. The bench instead reads the live count after the first byte, expects 0xFFFF with `busy` still high, and then ends the run with reset.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_GRD, S_GWR, S_LINE, S_PLO, S_PHI, S_DRD, S_DWR, S_ELO, S_EHI
  } dmac_st_e;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_PORT  = 4'd1;
  localparam logic [3:0] A_SRC_L = 4'd2;
  localparam logic [3:0] A_SRC_H = 4'd3;
  localparam logic [3:0] A_CNT_L = 4'd4;
  localparam logic [3:0] A_CNT_H = 4'd5;
  localparam logic [3:0] A_IND_L = 4'd6;
  localparam logic [3:0] A_IND_H = 4'd7;
  localparam logic [3:0] A_TBL_L = 4'd8;
  localparam logic [3:0] A_TBL_H = 4'd9;

endpackage

// File: rtl/dmac_slot.sv
`timescale 1ns/1ps
module dmac_slot #(
  parameter int SLOT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic slot_first,
  output logic slot_end
);
  localparam int SC = (SLOT_CYC < 2) ? 2 : SLOT_CYC;
  localparam int W  = $clog2(SC);
  localparam logic [W-1:0] LAST = W'(SC - 1);

  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (!active)           cnt_n = '0;
    else if (cnt_q == LAST) cnt_n = '0;
    else                   cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign slot_first = active && (cnt_q == '0);
  assign slot_end   = active && (cnt_q == LAST);

  p_slot_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (cnt_q == '0))
    else $error("slot counter did not wrap");

endmodule

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
  import dmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [3:0]  cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic        busy,
  input  logic        tbl_mode,
  input  logic        src_upd,
  input  logic [15:0] src_nxt,
  input  logic        cnt_upd,
  input  logic [15:0] cnt_nxt,
  input  logic        ind_upd,
  input  logic [15:0] ind_nxt,
  input  logic        tbl_upd,
  input  logic [15:0] tbl_nxt,
  output logic [1:0]  ctrl,
  output logic [7:0]  port,
  output logic [15:0] src,
  output logic [15:0] cnt,
  output logic [15:0] ind,
  output logic [15:0] tbl
);
  logic [1:0]  ctrl_q, ctrl_n;
  logic [7:0]  port_q, port_n;
  logic [15:0] src_q, src_n, cnt_q, cnt_n, ind_q, ind_n, tbl_q, tbl_n;
  logic        wr_ok, reg_en;

  assign wr_ok  = cpu_we && !busy;
  assign reg_en = wr_ok || src_upd || cnt_upd || ind_upd || tbl_upd;

  always_comb begin
    ctrl_n = ctrl_q;
    port_n = port_q;
    src_n  = src_q;
    cnt_n  = cnt_q;
    ind_n  = ind_q;
    tbl_n  = tbl_q;
    if (wr_ok) begin
      case (cpu_addr)
        A_CTRL:  ctrl_n       = cpu_wdata[1:0];
        A_PORT:  port_n       = cpu_wdata;
        A_SRC_L: src_n[7:0]   = cpu_wdata;
        A_SRC_H: src_n[15:8]  = cpu_wdata;
        A_CNT_L: cnt_n[7:0]   = cpu_wdata;
        A_CNT_H: cnt_n[15:8]  = cpu_wdata;
        A_IND_L: ind_n[7:0]   = cpu_wdata;
        A_IND_H: ind_n[15:8]  = cpu_wdata;
        default: ;
      endcase
    end
    if (src_upd) src_n = src_nxt;
    if (cnt_upd) cnt_n = cnt_nxt;
    if (ind_upd) ind_n = ind_nxt;
    if (tbl_upd) tbl_n = tbl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      port_q <= '0;
      src_q  <= '0;
      cnt_q  <= '0;
      ind_q  <= '0;
      tbl_q  <= '0;
    end else if (reg_en) begin
      ctrl_q <= ctrl_n;
      port_q <= port_n;
      src_q  <= src_n;
      cnt_q  <= cnt_n;
      ind_q  <= ind_n;
      tbl_q  <= tbl_n;
    end
  end

  always_comb begin
    case (cpu_addr)
      A_CTRL:  cpu_rdata = {6'd0, ctrl_q};
      A_PORT:  cpu_rdata = port_q;
      A_SRC_L: cpu_rdata = src_q[7:0];
      A_SRC_H: cpu_rdata = src_q[15:8];
      A_CNT_L: cpu_rdata = cnt_q[7:0];
      A_CNT_H: cpu_rdata = cnt_q[15:8];
      A_IND_L: cpu_rdata = ind_q[7:0];
      A_IND_H: cpu_rdata = ind_q[15:8];
      A_TBL_L: cpu_rdata = tbl_q[7:0];
      A_TBL_H: cpu_rdata = tbl_q[15:8];
      default: cpu_rdata = 8'h00;
    endcase
  end

  assign ctrl = ctrl_q;
  assign port = port_q;
  assign src  = src_q;
  assign cnt  = cnt_q;
  assign ind  = ind_q;
  assign tbl  = tbl_q;

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_upd |=> (cnt_q == $past(cnt_q) - 16'd1))
    else $error("count did not step by one");

  p_src_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    src_upd |=> ((src_q == $past(src_q) + 16'd1) || (src_q == $past(src_q) - 16'd1)))
    else $error("source did not step by one");

  p_start_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_mode |=> $stable(src_q))
    else $error("start address changed during table walk");

  p_busy_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_we) |=> ($stable(ctrl_q) && $stable(port_q)))
    else $error("write accepted while busy");

endmodule

// File: rtl/dmac_engine.sv
`timescale 1ns/1ps
module dmac_engine
  import dmac_pkg::*;
#(
  parameter logic [7:0] PORT_PAGE = 8'h21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        frame_start,
  input  logic        last_chan,
  input  logic        slot_first,
  input  logic        slot_end,
  input  logic [1:0]  ctrl,
  input  logic [7:0]  port,
  input  logic [15:0] src,
  input  logic [15:0] cnt,
  input  logic [15:0] ind,
  input  logic [15:0] tbl,
  input  logic [7:0]  bus_rdata,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  output logic        busy,
  output logic        done,
  output logic        tbl_mode,
  output logic        src_upd,
  output logic [15:0] src_nxt,
  output logic        cnt_upd,
  output logic [15:0] cnt_nxt,
  output logic        ind_upd,
  output logic [15:0] ind_nxt,
  output logic        tbl_upd,
  output logic [15:0] tbl_nxt
);
  dmac_st_e   st_q, st_n;
  logic [7:0] data_q;
  logic [6:0] rem_q, rem_n;
  logic       done_q, done_n;
  logic       is_rd, is_wr, cap_en, down, ptr_mode;

  assign down     = ctrl[0];
  assign ptr_mode = ctrl[1];

  always_comb begin
    is_rd = 1'b0;
    is_wr = 1'b0;
    case (st_q)
      S_GRD, S_LINE, S_PLO, S_PHI, S_DRD, S_ELO, S_EHI: is_rd = 1'b1;
      S_GWR, S_DWR:                                     is_wr = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (st_q)
      S_GRD:                        bus_addr = src;
      S_DRD:                        bus_addr = ptr_mode ? ind : tbl;
      S_GWR, S_DWR:                 bus_addr = {PORT_PAGE, port};
      S_LINE, S_PLO, S_PHI,
      S_ELO, S_EHI:                 bus_addr = tbl;
      default:                      bus_addr = 16'h0000;
    endcase
  end

  assign busy      = (st_q != S_IDLE);
  assign tbl_mode  = busy && (st_q != S_GRD) && (st_q != S_GWR);
  assign bus_rd    = slot_first && is_rd;
  assign bus_wr    = slot_first && is_wr;
  assign bus_wdata = data_q;
  assign cap_en    = slot_first && is_rd;
  assign done      = done_q;

  always_comb begin
    st_n    = st_q;
    rem_n   = rem_q;
    done_n  = 1'b0;
    src_upd = 1'b0;
    src_nxt = src;
    cnt_upd = 1'b0;
    cnt_nxt = cnt;
    ind_upd = 1'b0;
    ind_nxt = ind;
    tbl_upd = 1'b0;
    tbl_nxt = tbl;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_n = S_GRD;
        end else if (frame_start) begin
          tbl_upd = 1'b1;
          tbl_nxt = src;
          st_n    = S_LINE;
        end
      end
      S_GRD: if (slot_end) begin
        src_upd = 1'b1;
        src_nxt = down ? src - 16'd1 : src + 16'd1;
        cnt_upd = 1'b1;
        cnt_nxt = cnt - 16'd1;
        st_n    = S_GWR;
      end
      S_GWR: if (slot_end) begin
        if (cnt == 16'h0000) begin
          st_n   = S_IDLE;
          done_n = 1'b1;
        end else begin
          st_n = S_GRD;
        end
      end
      S_LINE: if (slot_end) begin
        tbl_upd = 1'b1;
        tbl_nxt = tbl + 16'd1;
        if (data_q[6:0] == 7'd0) begin
          if (ptr_mode) begin
            st_n = S_ELO;
          end else begin
            st_n   = S_IDLE;
            done_n = 1'b1;
          end
        end else begin
          rem_n = data_q[7] ? data_q[6:0] : 7'd1;
          st_n  = ptr_mode ? S_PLO : S_DRD;
        end
      end
      S_PLO: if (slot_end) begin
        tbl_upd = 1'b1;
        tbl_nxt = tbl + 16'd1;
        ind_upd = 1'b1;
        ind_nxt = {ind[15:8], data_q};
        st_n    = S_PHI;
      end
      S_PHI: if (slot_end) begin
        tbl_upd = 1'b1;
        tbl_nxt = tbl + 16'd1;
        ind_upd = 1'b1;
        ind_nxt = {data_q, ind[7:0]};
        st_n    = S_DRD;
      end
      S_DRD: if (slot_end) begin
        if (ptr_mode) begin
          ind_upd = 1'b1;
          ind_nxt = ind + 16'd1;
        end else begin
          tbl_upd = 1'b1;
          tbl_nxt = tbl + 16'd1;
        end
        rem_n = rem_q - 7'd1;
        st_n  = S_DWR;
      end
      S_DWR: if (slot_end) begin
        st_n = (rem_q == 7'd0) ? S_LINE : S_DRD;
      end
      S_ELO: if (slot_end) begin
        tbl_upd = 1'b1;
        tbl_nxt = tbl + 16'd1;
        ind_upd = 1'b1;
        if (last_chan) begin
          ind_nxt = {data_q, 8'h00};
          st_n    = S_IDLE;
          done_n  = 1'b1;
        end else begin
          ind_nxt = {ind[15:8], data_q};
          st_n    = S_EHI;
        end
      end
      S_EHI: if (slot_end) begin
        tbl_upd = 1'b1;
        tbl_nxt = tbl + 16'd1;
        ind_upd = 1'b1;
        ind_nxt = {data_q, ind[7:0]};
        st_n    = S_IDLE;
        done_n  = 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      rem_q  <= rem_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= bus_rdata;
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done longer than one cycle");

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy)
    else $error("done while busy");

  p_strobe_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> !(bus_rd || bus_wr))
    else $error("back-to-back strobes");

  p_quirk_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ELO && slot_end && last_chan) |=> (done_q && ind[7:0] == 8'h00))
    else $error("short table end mismatch");

  p_tbl_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && frame_start && !start) |=> (tbl == $past(src)))
    else $error("table pointer not reloaded");

endmodule

// File: rtl/dmac_chan.sv
`timescale 1ns/1ps
module dmac_chan #(
  parameter int         SLOT_CYC  = 8,
  parameter logic [7:0] PORT_PAGE = 8'h21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [3:0]  cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic        start,
  input  logic        frame_start,
  input  logic        last_chan,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        busy,
  output logic        done
);
  logic        slot_first, slot_end, tbl_mode;
  logic        src_upd, cnt_upd, ind_upd, tbl_upd;
  logic [15:0] src_nxt, cnt_nxt, ind_nxt, tbl_nxt;
  logic [1:0]  ctrl;
  logic [7:0]  port;
  logic [15:0] src, cnt, ind, tbl;

  dmac_slot #(.SLOT_CYC(SLOT_CYC)) u_slot (
    .clk(clk), .rst_n(rst_n), .active(busy),
    .slot_first(slot_first), .slot_end(slot_end)
  );

  dmac_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .busy(busy), .tbl_mode(tbl_mode),
    .src_upd(src_upd), .src_nxt(src_nxt), .cnt_upd(cnt_upd), .cnt_nxt(cnt_nxt),
    .ind_upd(ind_upd), .ind_nxt(ind_nxt), .tbl_upd(tbl_upd), .tbl_nxt(tbl_nxt),
    .ctrl(ctrl), .port(port), .src(src), .cnt(cnt), .ind(ind), .tbl(tbl)
  );

  dmac_engine #(.PORT_PAGE(PORT_PAGE)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start(start), .frame_start(frame_start), .last_chan(last_chan),
    .slot_first(slot_first), .slot_end(slot_end),
    .ctrl(ctrl), .port(port), .src(src), .cnt(cnt), .ind(ind), .tbl(tbl),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .busy(busy), .done(done), .tbl_mode(tbl_mode),
    .src_upd(src_upd), .src_nxt(src_nxt), .cnt_upd(cnt_upd), .cnt_nxt(cnt_nxt),
    .ind_upd(ind_upd), .ind_nxt(ind_nxt), .tbl_upd(tbl_upd), .tbl_nxt(tbl_nxt)
  );

endmodule

// File: tb/test_dmac_chan.sv
`timescale 1ns/1ps
module test_dmac_chan;
  import dmac_pkg::*;

  localparam logic [7:0] PAGE = 8'h21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_addr = 4'd0;
  logic [7:0]  cpu_wdata = 8'd0;
  logic [7:0]  cpu_rdata;
  logic        start = 1'b0, frame_start = 1'b0, last_chan = 1'b0;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  typedef struct {
    bit          wr;
    logic [15:0] a;
    logic [7:0]  d;
    string       tag;
  } ev_t;
  ev_t q[$];

  logic [7:0] tmem [0:255];

  always #4 clk = ~clk;

  dmac_chan i_dmac_chan (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .start(start),
    .frame_start(frame_start), .last_chan(last_chan), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done)
  );

  function automatic logic [7:0] hsh(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always_comb bus_rdata = (bus_addr[15:8] == 8'h40) ? tmem[bus_addr[7:0]] : hsh(bus_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_rd(input logic [15:0] a, input string tag);
    ev_t e;
    e.wr = 1'b0; e.a = a; e.d = 8'h00; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    ev_t e;
    e.wr = 1'b1; e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n && (bus_rd || bus_wr)) begin
      if (q.size() == 0) begin
        chk("R4 unexpected bus access", {15'd0, bus_wr, bus_addr}, 32'hFFFF_FFFF);
      end else begin
        ev_t e;
        e = q.pop_front();
        chk({e.tag, " kind"}, {31'd0, bus_wr}, {31'd0, e.wr});
        chk({e.tag, " addr"}, {16'd0, bus_addr}, {16'd0, e.a});
        if (e.wr) chk({e.tag, " data"}, {24'd0, bus_wdata}, {24'd0, e.d});
      end
    end
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] d);
    wr(a, d[7:0]);
    wr(a + 4'd1, d[15:8]);
  endtask

  task automatic wait_done(output int n);
    n = 1;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R9 done seen", {31'd0, done}, 32'd1);
    chk("R9 idle at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done}, 32'd0);
    chk("R4 queue drained", q.size(), 32'd0);
  endtask

  task automatic go_block(output int n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(n);
  endtask

  task automatic go_frame(output int n);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    wait_done(n);
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    int n, n_norm, n_short;

    for (int i = 0; i < 256; i++) tmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), b);
      chk("R11 reset register", {24'd0, b}, 32'd0);
    end
    chk("R11 busy low", {31'd0, busy}, 32'd0);
    chk("R11 done low", {31'd0, done}, 32'd0);

    // R1/R2/R4 upward block
    wr(A_CTRL, 8'h00);
    wr(A_PORT, 8'h18);
    wr16(A_SRC_L, 16'h1230);
    wr16(A_CNT_L, 16'd3);
    for (int i = 0; i < 3; i++) begin
      exp_rd(16'h1230 + 16'(i), "R1 up read");
      exp_wr({PAGE, 8'h18}, hsh(16'h1230 + 16'(i)), "R4 port write");
    end
    go_block(n);
    chk("R9 block duration", n, 3 * 16 + 1);
    rd16(A_SRC_L, v); chk("R1 source after up run", {16'd0, v}, 32'h1233);
    rd16(A_CNT_L, v); chk("R2 count reads zero", {16'd0, v}, 32'd0);

    // R3 restart continues
    wr16(A_CNT_L, 16'd2);
    exp_rd(16'h1233, "R3 continue read");
    exp_wr({PAGE, 8'h18}, hsh(16'h1233), "R3 continue write");
    exp_rd(16'h1234, "R3 continue read");
    exp_wr({PAGE, 8'h18}, hsh(16'h1234), "R3 continue write");
    go_block(n);
    rd16(A_SRC_L, v); chk("R3 source continued", {16'd0, v}, 32'h1235);

    // R1 downward
    wr(A_CTRL, 8'h01);
    wr16(A_SRC_L, 16'h2000);
    wr16(A_CNT_L, 16'd2);
    exp_rd(16'h2000, "R1 down read");
    exp_wr({PAGE, 8'h18}, hsh(16'h2000), "R4 port write");
    exp_rd(16'h1FFF, "R1 down read");
    exp_wr({PAGE, 8'h18}, hsh(16'h1FFF), "R4 port write");
    go_block(n);
    rd16(A_SRC_L, v); chk("R1 source after down run", {16'd0, v}, 32'h1FFE);

    // R10 writes ignored while busy, live reads
    wr(A_CTRL, 8'h00);
    wr16(A_SRC_L, 16'h3000);
    wr16(A_CNT_L, 16'd4);
    for (int i = 0; i < 4; i++) begin
      exp_rd(16'h3000 + 16'(i), "R10 read unaffected");
      exp_wr({PAGE, 8'h18}, hsh(16'h3000 + 16'(i)), "R10 port unaffected");
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (11) @(negedge clk);
    rd(A_CNT_L, b);
    chk("R10 live count read", {24'd0, b}, 32'd3);
    chk("R10 busy during run", {31'd0, busy}, 32'd1);
    wr(A_PORT, 8'h77);
    wr(A_SRC_L, 8'hAA);
    wait_done(n);
    rd(A_PORT, b); chk("R10 port write ignored", {24'd0, b}, 32'h18);
    rd16(A_SRC_L, v); chk("R10 source write ignored", {16'd0, v}, 32'h3004);

    // R2 zero count means 65536
    wr16(A_SRC_L, 16'h5000);
    wr16(A_CNT_L, 16'h0000);
    exp_rd(16'h5000, "R2 zero count read");
    exp_wr({PAGE, 8'h18}, hsh(16'h5000), "R2 zero count write");
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (11) @(negedge clk);
    rd16(A_CNT_L, v);
    chk("R2 count wrapped to FFFF", {16'd0, v}, 32'hFFFF);
    chk("R2 still busy", {31'd0, busy}, 32'd1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    q.delete();
    rst_n = 1'b1;
    chk("R11 busy low after reset", {31'd0, busy}, 32'd0);
    rd16(A_CNT_L, v); chk("R11 count cleared", {16'd0, v}, 32'd0);

    // R5/R6 direct table, two frames
    tmem[0] = 8'h82; tmem[1] = 8'hA1; tmem[2] = 8'hB2;
    tmem[3] = 8'h05; tmem[4] = 8'hC3; tmem[5] = 8'h00;
    wr(A_CTRL, 8'h00);
    wr(A_PORT, 8'h22);
    wr16(A_SRC_L, 16'h4000);
    for (int f = 0; f < 2; f++) begin
      exp_rd(16'h4000, "R6 header");
      exp_rd(16'h4001, "R6 repeat data");
      exp_wr({PAGE, 8'h22}, 8'hA1, "R6 repeat write");
      exp_rd(16'h4002, "R6 repeat data");
      exp_wr({PAGE, 8'h22}, 8'hB2, "R6 repeat write");
      exp_rd(16'h4003, "R6 header");
      exp_rd(16'h4004, "R6 single data");
      exp_wr({PAGE, 8'h22}, 8'hC3, "R6 single write");
      exp_rd(16'h4005, "R6 end header");
      go_frame(n);
      rd16(A_SRC_L, v); chk("R5 start preserved", {16'd0, v}, 32'h4000);
      rd16(A_TBL_L, v); chk("R5 table pointer advanced", {16'd0, v}, 32'h4006);
    end

    // R7/R8 pointer table, normal end then short end
    tmem[16] = 8'h82; tmem[17] = 8'h00; tmem[18] = 8'h60;
    tmem[19] = 8'h01; tmem[20] = 8'h34; tmem[21] = 8'h12;
    tmem[22] = 8'h00; tmem[23] = 8'hC5; tmem[24] = 8'h7E;
    wr(A_CTRL, 8'h02);
    wr16(A_SRC_L, 16'h4010);
    for (int p = 0; p < 2; p++) begin
      last_chan = (p == 1);
      exp_rd(16'h4010, "R7 header");
      exp_rd(16'h4011, "R7 pointer lo");
      exp_rd(16'h4012, "R7 pointer hi");
      exp_rd(16'h6000, "R7 indirect read");
      exp_wr({PAGE, 8'h22}, hsh(16'h6000), "R7 indirect write");
      exp_rd(16'h6001, "R7 indirect read");
      exp_wr({PAGE, 8'h22}, hsh(16'h6001), "R7 indirect write");
      exp_rd(16'h4013, "R7 header");
      exp_rd(16'h4014, "R7 pointer lo");
      exp_rd(16'h4015, "R7 pointer hi");
      exp_rd(16'h1234, "R7 indirect read");
      exp_wr({PAGE, 8'h22}, hsh(16'h1234), "R7 indirect write");
      exp_rd(16'h4016, "R8 end header");
      exp_rd(16'h4017, "R8 end byte lo");
      if (p == 0) exp_rd(16'h4018, "R8 end byte hi");
      go_frame(n);
      rd16(A_IND_L, v);
      if (p == 0) begin
        n_norm = n;
        chk("R8 normal end pointer", {16'd0, v}, 32'h7EC5);
      end else begin
        n_short = n;
        chk("R8 short end pointer", {16'd0, v}, 32'hC500);
      end
    end
    last_chan = 1'b0;
    chk("R8 short end saves one slot", n_norm - n_short, 32'd8);
    chk("R7 normal walk duration", n_norm, 15 * 8 + 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule